// File: doc/BRIEF.md
# Configuration-Space Object Mailbox

This block is the device side of a request/response mailbox that host software reaches through 32-bit configuration writes and reads at four fixed offsets. The host pushes a request object into a write-mailbox register one dword at a time. It then writes the control register with the start bit set and polls the status register until a response is flagged as available. The response is also pulled one dword at a time: reading the read-mailbox register returns the current dword, and any write to that register moves on to the next dword.

A request header carries a 16-bit vendor ID and an 8-bit object type. The block checks the request and dispatches on that pair to one of four small responders:
- a discovery responder that lists the four supported objects, one per index;
- a measurement stub that echoes its argument;
- a compliance responder that returns a fixed capability word;
- an attribute-table reader that returns a table computed from the request code.

Malformed or unknown requests raise a sticky error and produce no response. An abort written to the control register cancels any exchange and clears the error.

Top module: `cfg_obj_mbox`

## Requirements
- R1: After reset the status register (offset 0x16C) reads zero and the read mailbox (offset 0x174) reads zero.
- R2: A start write (offset 0x168, bit 31 set, bit 0 clear) with a valid request in the mailbox sets status bit 0 (busy) for exactly one cycle. It then sets status bit 31 (ready) with bit 0 clear. Response dword 0 repeats the request's vendor ID in bits [15:0] and type in bits [23:16], with bits [31:24] zero. Response dword 1 holds the response length in dwords in bits [15:0].
- R3: A discovery request (vendor 0x0001, type 0) with index 0 to 3 in request dword 2 answers with a 3-dword response. Dword 2 holds the listed vendor in [15:0], the listed type in [23:16] and the next index in [31:24]. The list is, by index: (0x0001,0), (0x0001,1), (0x1E98,0), (0x1E98,2). The next index after entry 3 is 0.
- R4: A measurement request (vendor 0x0001, type 1) answers with 3 dwords, and dword 2 equals bits [15:0] of request dword 2, zero-extended.
- R5: A compliance request (vendor 0x1E98, type 0) answers with 3 dwords, and dword 2 is the parameter COMPL_CAPS (default 0x000000A1) whatever request dword 2 holds.
- R6: A table request (vendor 0x1E98, type 2) answers with RSP_DEPTH dwords (default 8). Payload dword k (k from 0) is {0xDA, code[7:0], 0x00, k[7:0]}, where code is request dword 2.
- R7: A write of any value to the read mailbox while ready advances to the next dword. The advance after the last dword clears ready, and from then on the read mailbox reads zero.
- R8: An unknown vendor/type pair sets status bit 1 (error) after the start write, and ready is never set. A further start write while the error is set leaves busy and ready clear.
- R9: A request whose dword 1 length field (bits [15:0]) differs from the number of dwords written, or that has fewer than 3 dwords, sets the error bit with no response.
- R10: Writing more than REQ_DEPTH dwords (default 8) to the write mailbox sets the error bit at the extra write.
- R11: A control write with bit 0 set (abort) clears error, busy and ready, and empties the request buffer, even in the middle of a response. A following valid exchange completes normally.
- R12: A discovery request with an index above 3 sets the error bit with no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration write strobe, one cycle per write |
| cfgAddr | input | 12 | Configuration byte offset |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Read data for cfgAddr (status, read mailbox, zero elsewhere) |

## Verification
The hardest situation to reach from the ports is the one-cycle busy window between the start write and ready. The bench reads the status register at the negative edge right after the start write lands, then again one edge later, so both the busy and the ready levels are pinned to exact cycles. Overflow also takes some setting up: the bench streams one more dword than the buffer holds, then checks that a start write is refused and that abort recovers the block.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam logic [11:0] OFS_CTRL   = 12'h168;
  localparam logic [11:0] OFS_STATUS = 12'h16C;
  localparam logic [11:0] OFS_WMB    = 12'h170;
  localparam logic [11:0] OFS_RMB    = 12'h174;

  localparam logic [15:0] VID_BASE = 16'h0001;
  localparam logic [15:0] VID_EXT  = 16'h1E98;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PARSE = 2'd1,
    S_READY = 2'd2
  } mbxState_t;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_DISC  = 3'd1,
    K_MEAS  = 3'd2,
    K_COMPL = 3'd3,
    K_TABLE = 3'd4
  } objKind_t;

  typedef struct packed {
    logic pushReq;
    logic clrReq;
    logic build;
    logic advance;
  } mbxStrobes_t;

endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int REQ_DEPTH = 8,
  parameter int RSP_DEPTH = 8,
  parameter logic [31:0] COMPL_CAPS = 32'h0000_00A1
) (
  input  logic        clk,
  input  logic        rstN,
  input  mbxStrobes_t stb,
  input  logic [31:0] wrData,
  output logic        reqFull,
  output logic        reqValid,
  output logic        rspLast,
  output logic [31:0] rspWord
);

  localparam int REQ_IW    = $clog2(REQ_DEPTH);
  localparam int REQ_CW    = $clog2(REQ_DEPTH + 1);
  localparam int RSP_PW    = $clog2(RSP_DEPTH);
  localparam int TBL_WORDS = RSP_DEPTH - 2;

  logic [31:0]       reqMem [REQ_DEPTH];
  logic [REQ_CW-1:0] reqCnt;
  logic [31:0]       rspMem [RSP_DEPTH];
  logic [31:0]       rspNext [RSP_DEPTH];
  logic [RSP_PW:0]   rspLen, rspLenNext;
  logic [RSP_PW-1:0] rspPtr;

  // request buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            reqCnt <= '0;
    else if (stb.clrReq)  reqCnt <= '0;
    else if (stb.pushReq) reqCnt <= reqCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.pushReq) reqMem[reqCnt[REQ_IW-1:0]] <= wrData;
  end

  assign reqFull = (32'(reqCnt) >= REQ_DEPTH);

  // header decode
  logic [15:0] hdrVendor;
  logic [7:0]  hdrType;
  logic [15:0] lenField;
  logic [31:0] reqArg;
  objKind_t    kind;

  assign hdrVendor = reqMem[0][15:0];
  assign hdrType   = reqMem[0][23:16];
  assign lenField  = reqMem[1][15:0];
  assign reqArg    = reqMem[2];

  always_comb begin
    kind = K_NONE;
    if (hdrVendor == VID_BASE && hdrType == 8'd0) kind = K_DISC;
    if (hdrVendor == VID_BASE && hdrType == 8'd1) kind = K_MEAS;
    if (hdrVendor == VID_EXT  && hdrType == 8'd0) kind = K_COMPL;
    if (hdrVendor == VID_EXT  && hdrType == 8'd2) kind = K_TABLE;
  end

  assign reqValid = (kind != K_NONE) && (32'(reqCnt) >= 3) &&
                    (32'(lenField) == 32'(reqCnt)) &&
                    !(kind == K_DISC && reqArg > 32'd3);

  function automatic logic [31:0] discEntry(input logic [1:0] idx);
    case (idx)
      2'd0:    discEntry = {8'd1, 8'd0, VID_BASE};
      2'd1:    discEntry = {8'd2, 8'd1, VID_BASE};
      2'd2:    discEntry = {8'd3, 8'd0, VID_EXT};
      default: discEntry = {8'd0, 8'd2, VID_EXT};
    endcase
  endfunction

  // response assembly
  always_comb begin
    rspLenNext = (kind == K_TABLE) ? (RSP_PW + 1)'(RSP_DEPTH) : (RSP_PW + 1)'(3);
    for (int i = 0; i < RSP_DEPTH; i++) rspNext[i] = '0;
    rspNext[0] = {8'd0, hdrType, hdrVendor};
    rspNext[1] = 32'(rspLenNext);
    case (kind)
      K_DISC:  rspNext[2] = discEntry(reqArg[1:0]);
      K_MEAS:  rspNext[2] = {16'd0, reqArg[15:0]};
      K_COMPL: rspNext[2] = COMPL_CAPS;
      K_TABLE: begin
        for (int k = 0; k < TBL_WORDS; k++)
          rspNext[k + 2] = {8'hDA, reqArg[7:0], 8'h00, 8'(k)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspLen <= '0;
      rspPtr <= '0;
    end else if (stb.build) begin
      rspLen <= rspLenNext;
      rspPtr <= '0;
    end else if (stb.advance) begin
      rspPtr <= rspPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.build)
      for (int i = 0; i < RSP_DEPTH; i++) rspMem[i] <= rspNext[i];
  end

  assign rspLast = ({1'b0, rspPtr} == rspLen - 1'b1);
  assign rspWord = rspMem[rspPtr];

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushReq |-> (32'(reqCnt) < REQ_DEPTH));

  // R7
  advance_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |-> ({1'b0, rspPtr} < rspLen));

  // R6
  rsp_len_fits_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.build |=> (rspLen >= 3 && 32'(rspLen) <= RSP_DEPTH));

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWr,
  input  logic [11:0] cfgAddr,
  input  logic        goBit,
  input  logic        abortBit,
  input  logic        reqFull,
  input  logic        reqValid,
  input  logic        rspLast,
  output mbxStrobes_t stb,
  output logic        busy,
  output logic        ready,
  output logic        errFlag
);

  mbxState_t state;
  logic wrCtrl, abortReq, goReq, wrWmb, wrRmb, idleOpen;

  assign wrCtrl   = cfgWr && (cfgAddr == OFS_CTRL);
  assign abortReq = wrCtrl && abortBit;
  assign goReq    = wrCtrl && goBit && !abortBit;
  assign wrWmb    = cfgWr && (cfgAddr == OFS_WMB);
  assign wrRmb    = cfgWr && (cfgAddr == OFS_RMB);
  assign idleOpen = (state == S_IDLE) && !errFlag;

  always_comb begin
    stb = '0;
    if (abortReq) begin
      stb.clrReq = 1'b1;
    end else begin
      case (state)
        S_IDLE:  if (wrWmb && idleOpen && !reqFull) stb.pushReq = 1'b1;
        S_PARSE: if (reqValid) stb.build = 1'b1;
        S_READY: if (wrRmb) begin
          stb.advance = 1'b1;
          if (rspLast) stb.clrReq = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      errFlag <= 1'b0;
    end else if (abortReq) begin
      state   <= S_IDLE;
      errFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wrWmb && idleOpen && reqFull) errFlag <= 1'b1;
          else if (goReq && idleOpen)       state   <= S_PARSE;
        end
        S_PARSE: begin
          if (reqValid) state <= S_READY;
          else begin
            state   <= S_IDLE;
            errFlag <= 1'b1;
          end
        end
        S_READY: if (wrRmb && rspLast) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = (state == S_PARSE);
  assign ready = (state == S_READY);

  // R2
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R8
  err_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !ready);

  // R11
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!errFlag && !busy && !ready));

endmodule

// File: rtl/cfg_obj_mbox.sv
module cfg_obj_mbox
  import mbx_pkg::*;
#(
  parameter int REQ_DEPTH = 8,
  parameter int RSP_DEPTH = 8,
  parameter logic [31:0] COMPL_CAPS = 32'h0000_00A1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWr,
  input  logic [11:0] cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata
);

  mbxStrobes_t stb;
  logic reqFull, reqValid, rspLast, busy, ready, errFlag;
  logic [31:0] rspWord;

  mbx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWr    (cfgWr),
    .cfgAddr  (cfgAddr),
    .goBit    (cfgWdata[31]),
    .abortBit (cfgWdata[0]),
    .reqFull  (reqFull),
    .reqValid (reqValid),
    .rspLast  (rspLast),
    .stb      (stb),
    .busy     (busy),
    .ready    (ready),
    .errFlag  (errFlag)
  );

  mbx_datapath #(
    .REQ_DEPTH  (REQ_DEPTH),
    .RSP_DEPTH  (RSP_DEPTH),
    .COMPL_CAPS (COMPL_CAPS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (cfgWdata),
    .reqFull  (reqFull),
    .reqValid (reqValid),
    .rspLast  (rspLast),
    .rspWord  (rspWord)
  );

  always_comb begin
    case (cfgAddr)
      OFS_STATUS: cfgRdata = {ready, 29'd0, errFlag, busy};
      OFS_RMB:    cfgRdata = ready ? rspWord : 32'd0;
      default:    cfgRdata = 32'd0;
    endcase
  end

endmodule

// File: tb/sim_cfg_obj_mbox.sv
module sim_cfg_obj_mbox;

  localparam logic [11:0] A_CTRL = 12'h168;
  localparam logic [11:0] A_STAT = 12'h16C;
  localparam logic [11:0] A_WMB  = 12'h170;
  localparam logic [11:0] A_RMB  = 12'h174;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfg_obj_mbox u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic cfgWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWr = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWr = 1'b0; cfgWdata = '0;
  endtask

  task automatic cfgRead(input logic [11:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdata;
  endtask

  task automatic sendReq(input logic [31:0] d0, d1, d2);
    cfgWrite(A_WMB, d0);
    cfgWrite(A_WMB, d1);
    cfgWrite(A_WMB, d2);
  endtask

  task automatic waitReady(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 16; i++) begin
      cfgRead(A_STAT, s);
      if (s[31]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic xchg(input string tag, input logic [31:0] d0, d1, d2,
                      input int n, input logic [31:0] e [8]);
    bit ok;
    logic [31:0] v;
    sendReq(d0, d1, d2);
    cfgWrite(A_CTRL, 32'h8000_0000);
    waitReady(ok);
    check({tag, " ready"}, 32'(ok), 32'd1);
    for (int i = 0; i < n; i++) begin
      cfgRead(A_RMB, v);
      check($sformatf("%s dw%0d", tag, i), v, e[i]);
      cfgWrite(A_RMB, 32'h1);
    end
    cfgRead(A_STAT, v);
    check({tag, " R7 status after last"}, v, 32'd0);
    cfgRead(A_RMB, v);
    check({tag, " R7 rmb after last"}, v, 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    cfgRead(A_STAT, v); check("R1 status", v, 32'd0);
    cfgRead(A_RMB, v);  check("R1 rmb", v, 32'd0);
  endtask

  task automatic testBusyWindow();
    logic [31:0] v;
    sendReq(32'h0000_0001, 32'd3, 32'd0);
    cfgWrite(A_CTRL, 32'h8000_0000);
    cfgRead(A_STAT, v); check("R2 busy cycle", v, 32'h0000_0001);
    @(negedge clk);
    cfgRead(A_STAT, v); check("R2 ready cycle", v, 32'h8000_0000);
    cfgRead(A_RMB, v);  check("R2 header", v, 32'h0000_0001);
    cfgWrite(A_RMB, 32'h0);
    cfgRead(A_RMB, v);  check("R2 length", v, 32'd3);
    cfgWrite(A_CTRL, 32'h1);
  endtask

  task automatic testDiscovery();
    logic [31:0] e [8];
    logic [31:0] ent [4];
    ent[0] = 32'h0100_0001; ent[1] = 32'h0201_0001;
    ent[2] = 32'h0300_1E98; ent[3] = 32'h0002_1E98;
    for (int i = 0; i < 4; i++) begin
      foreach (e[j]) e[j] = '0;
      e[0] = 32'h0000_0001; e[1] = 32'd3; e[2] = ent[i];
      xchg($sformatf("R3 disc idx%0d", i), 32'h0000_0001, 32'd3, 32'(i), 3, e);
    end
  endtask

  task automatic testMeasure();
    logic [31:0] e [8];
    foreach (e[j]) e[j] = '0;
    e[0] = 32'h0001_0001; e[1] = 32'd3; e[2] = 32'h0000_BEEF;
    xchg("R4 meas", 32'h0001_0001, 32'd3, 32'h1234_BEEF, 3, e);
  endtask

  task automatic testCompliance();
    logic [31:0] e [8];
    foreach (e[j]) e[j] = '0;
    e[0] = 32'h0000_1E98; e[1] = 32'd3; e[2] = 32'h0000_00A1;
    xchg("R5 compl code0", 32'h0000_1E98, 32'd3, 32'd0, 3, e);
    xchg("R5 compl code1", 32'h0000_1E98, 32'd3, 32'd1, 3, e);
  endtask

  task automatic testTable();
    logic [31:0] e [8];
    e[0] = 32'h0002_1E98; e[1] = 32'd8;
    for (int k = 0; k < 6; k++) e[k + 2] = {8'hDA, 8'h3C, 8'h00, 8'(k)};
    xchg("R6 table", 32'h0002_1E98, 32'd3, 32'h0000_003C, 8, e);
  endtask

  task automatic expectError(input string tag);
    logic [31:0] v;
    cfgRead(A_STAT, v);
    check({tag, " error"}, v, 32'h0000_0002);
    cfgWrite(A_CTRL, 32'h1);
    cfgRead(A_STAT, v);
    check({tag, " R11 abort clears"}, v, 32'd0);
  endtask

  task automatic testUnknown();
    logic [31:0] v;
    sendReq(32'h0005_0001, 32'd3, 32'd0);
    cfgWrite(A_CTRL, 32'h8000_0000);
    @(negedge clk);
    cfgRead(A_STAT, v); check("R8 unknown", v, 32'h0000_0002);
    cfgWrite(A_CTRL, 32'h8000_0000);
    cfgRead(A_STAT, v); check("R8 go while error", v, 32'h0000_0002);
    @(negedge clk);
    cfgRead(A_RMB, v);  check("R8 no response", v, 32'd0);
    expectError("R8");
  endtask

  task automatic testLenMismatch();
    sendReq(32'h0000_0001, 32'd4, 32'd0);
    cfgWrite(A_CTRL, 32'h8000_0000);
    @(negedge clk);
    expectError("R9 len");
    cfgWrite(A_WMB, 32'h0000_0001);
    cfgWrite(A_WMB, 32'd2);
    cfgWrite(A_CTRL, 32'h8000_0000);
    @(negedge clk);
    expectError("R9 short");
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) cfgWrite(A_WMB, 32'h0000_0001);
    cfgRead(A_STAT, v); check("R10 full no error", v, 32'd0);
    cfgWrite(A_WMB, 32'h0000_0001);
    cfgRead(A_STAT, v); check("R10 overflow", v, 32'h0000_0002);
    cfgWrite(A_CTRL, 32'h8000_0000);
    @(negedge clk);
    expectError("R10");
  endtask

  task automatic testBadIndex();
    sendReq(32'h0000_0001, 32'd3, 32'd4);
    cfgWrite(A_CTRL, 32'h8000_0000);
    @(negedge clk);
    expectError("R12 index4");
  endtask

  task automatic testAbortMid();
    bit ok;
    logic [31:0] v;
    logic [31:0] e [8];
    sendReq(32'h0002_1E98, 32'd3, 32'd7);
    cfgWrite(A_CTRL, 32'h8000_0000);
    waitReady(ok);
    cfgWrite(A_RMB, 32'h0);
    cfgWrite(A_CTRL, 32'h1);
    cfgRead(A_STAT, v); check("R11 abort mid status", v, 32'd0);
    cfgRead(A_RMB, v);  check("R11 abort mid rmb", v, 32'd0);
    foreach (e[j]) e[j] = '0;
    e[0] = 32'h0000_0001; e[1] = 32'd3; e[2] = 32'h0201_0001;
    xchg("R11 after abort", 32'h0000_0001, 32'd3, 32'd1, 3, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBusyWindow();
    testDiscovery();
    testMeasure();
    testCompliance();
    testTable();
    testUnknown();
    testLenMismatch();
    testOverflow();
    testBadIndex();
    testAbortMid();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got=hung expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule